// File: doc/BRIEF.md
# Microcontroller Watchdog Timer with Reset Pulse

This block is the watchdog peripheral of a small 8-bit microcontroller. It divides the core clock into machine cycles (one machine cycle every `CLK_DIV` clocks). A prescaler of `PRE_BITS` bits counts the machine cycles, and its carry advances an up-counting watchdog count register. When that register steps past its all-ones value, the block drives an internal reset pulse of fixed width. At the end of the pulse the block clears its own counting state.

Firmware services the watchdog by reloading the count through a two-write sequence. The first write sets a load-unlock bit in the power control register. The second write stores the new count, and that store clears the unlock bit again. An active-low hardware pin is the only way to switch the watchdog on. No register bit can start or stop it. While the pin holds the watchdog on, the power-down request bit in the power control register cannot be set.

The controller has three states:
- `WD_IDLE`: the pin is high and the block is off.
- `WD_COUNT`: the block is counting.
- `WD_PULSE`: the reset pulse is being driven.

The transitions are:
- IDLE→COUNT when the pin goes low.
- COUNT→IDLE when the pin goes high.
- COUNT→PULSE on overflow.
- PULSE→COUNT or PULSE→IDLE when the pulse ends, chosen by the pin at that moment.

Top module: `wdog_core`

## Requirements
- R1: After reset the count reads 0, the power control register reads 0 and the reset pulse is low.
- R2: While enabled, the count advances by one every `CLK_DIV*2^PRE_BITS` clocks. After a valid load of value L, the pulse starts exactly `(256-L)*CLK_DIV*2^PRE_BITS` clock edges after the loading edge.
- R3: A load of 8'hFF gives the shortest interval (one count step). A load of 8'h00 gives the longest interval (256 count steps).
- R4: The reset pulse lasts `3*CLK_DIV` clocks (three machine cycles). When it ends, the count, the unlock bit and the power-down bit all read 0.
- R5: The pulse only starts from a count of all ones, and the count holds its value while the pulse is high.
- R6: While `wd_en_n` is high, the count does not change unless a valid load is made. No register write can enable or disable counting.
- R7: A write to the count register (`reg_sel`=1) made while the unlock bit is 0 leaves the count unchanged.
- R8: A write to the power control register (`reg_sel`=0) copies data bit 4 into the unlock bit. A successful count write clears the unlock bit on the same edge.
- R9: Data bit 1 of a power control write is the power-down bit, and `pwr_down` mirrors it. While `wd_en_n` is low, the power-down bit reads 0 and writes of 1 to it are ignored. While `wd_en_n` is high, the write is stored. All other bits of the power control register read 0.
- R10: A valid count load also clears the machine-cycle divider and the prescaler. The interval after a reload therefore does not depend on when the reload happened within a prescaler period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wd_en_n | input | 1 | Hardware enable pin: 0 runs the watchdog, 1 turns it off |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_sel | input | 1 | Write target: 0 = power control register, 1 = watchdog count |
| reg_wdata | input | 8 | Write data |
| pctl_rdata | output | 8 | Power control readback: bit 4 = unlock, bit 1 = power-down |
| count_rdata | output | 8 | Watchdog count readback |
| pwr_down | output | 1 | Power-down request, same value as power control bit 1 |
| sys_rst_pulse | output | 1 | Internal reset pulse |

## Verification
The checker assumes the following about the inputs:
- `wd_en_n` has already been synchronised to `clk`.
- At most one register write arrives per cycle.
- Writes that arrive while the reset pulse is high are dropped and need no checking.

Several properties look two cycles back at the pin. They do this because a pin change only reaches the counter after the state register has taken it.

The stimulus drives every input at the falling clock edge. It changes the pin only between intervals, when no pulse is due. It reloads the count early enough that no overflow arrives before the bench has queued the expected pulse width.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_COUNT = 2'd1,
        WD_PULSE = 2'd2
    } wd_state_e;

    localparam int unsigned PCTL_UNLOCK_BIT = 4;
    localparam int unsigned PCTL_PDOWN_BIT  = 1;

endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
    parameter int unsigned DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic mc_tick
);
    localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
        end
    end

    assign mc_tick = run && (div_q == LAST);
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int unsigned BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mc_tick,
    input  logic clr,
    output logic wrap
);
    logic [BITS-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
        end else if (mc_tick) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign wrap = mc_tick && (&pre_q);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clr,
    output logic [W-1:0] count,
    output logic         ovf
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (step && !(&cnt_q)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;
    assign ovf   = step && (&cnt_q);
endmodule

// File: rtl/wdog_ctrl_fsm.sv
module wdog_ctrl_fsm
    import wdog_pkg::*;
#(
    parameter int unsigned PULSE_CLKS = 36
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_en,
    input  logic ovf,
    output logic run,
    output logic rst_pulse,
    output logic pulse_done
);
    localparam int unsigned PW = $clog2(PULSE_CLKS + 1);
    localparam logic [PW-1:0] PLOAD = PW'(PULSE_CLKS - 1);

    wd_state_e     state_q, state_d;
    logic [PW-1:0] pcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= PLOAD;
        end else if (state_q != WD_PULSE) begin
            pcnt_q <= PLOAD;
        end else if (pcnt_q != '0) begin
            pcnt_q <= pcnt_q - 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE: begin
                if (pin_en) state_d = WD_COUNT;
            end
            WD_COUNT: begin
                if (ovf)          state_d = WD_PULSE;
                else if (!pin_en) state_d = WD_IDLE;
            end
            WD_PULSE: begin
                if (pcnt_q == '0) state_d = pin_en ? WD_COUNT : WD_IDLE;
            end
            default: state_d = WD_IDLE;
        endcase
    end

    always_comb begin
        run        = (state_q == WD_COUNT);
        rst_pulse  = (state_q == WD_PULSE);
        pulse_done = (state_q == WD_PULSE) && (pcnt_q == '0);
    end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int unsigned CLK_DIV  = 12,
    parameter int unsigned PRE_BITS = 11,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned PULSE_MC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wd_en_n,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] pctl_rdata,
    output logic [DATA_W-1:0] count_rdata,
    output logic              pwr_down,
    output logic              sys_rst_pulse
);
    localparam int unsigned PULSE_CLKS = PULSE_MC * CLK_DIV;

    logic pin_en, run, pulse_done, mc_tick, pre_wrap, ovf;
    logic wr_ok, cnt_wr, pctl_wr, tick_clr;
    logic unlock_q, pd_q;

    assign pin_en   = !wd_en_n;
    assign wr_ok    = reg_we && !sys_rst_pulse;
    assign cnt_wr   = wr_ok && reg_sel && unlock_q;
    assign pctl_wr  = wr_ok && !reg_sel;
    assign tick_clr = pulse_done || cnt_wr;

    wdog_ctrl_fsm #(.PULSE_CLKS(PULSE_CLKS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_en     (pin_en),
        .ovf        (ovf),
        .run        (run),
        .rst_pulse  (sys_rst_pulse),
        .pulse_done (pulse_done)
    );

    wdog_tick_gen #(.DIV(CLK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .clr     (tick_clr),
        .mc_tick (mc_tick)
    );

    wdog_prescaler #(.BITS(PRE_BITS)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .mc_tick (mc_tick),
        .clr     (tick_clr),
        .wrap    (pre_wrap)
    );

    wdog_counter #(.W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (pre_wrap),
        .load     (cnt_wr),
        .load_val (reg_wdata),
        .clr      (pulse_done),
        .count    (count_rdata),
        .ovf      (ovf)
    );

    // Unlock bit: set by a control write, dropped by every accepted count store.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unlock_q <= 1'b0;
        end else if (pulse_done || cnt_wr) begin
            unlock_q <= 1'b0;
        end else if (pctl_wr) begin
            unlock_q <= reg_wdata[PCTL_UNLOCK_BIT];
        end
    end

    // Power-down bit: forced low whenever the pin keeps the watchdog alive.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_q <= 1'b0;
        end else if (pulse_done || pin_en) begin
            pd_q <= 1'b0;
        end else if (pctl_wr) begin
            pd_q <= reg_wdata[PCTL_PDOWN_BIT];
        end
    end

    always_comb begin
        pctl_rdata                  = '0;
        pctl_rdata[PCTL_UNLOCK_BIT] = unlock_q;
        pctl_rdata[PCTL_PDOWN_BIT]  = pd_q;
    end

    assign pwr_down = pd_q;
endmodule

// File: rtl/wdog_core_chk.sv
module wdog_core_chk #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned PULSE_CLKS = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wd_en_n,
    input logic              reg_we,
    input logic              reg_sel,
    input logic              le_bit,
    input logic              pd_bit,
    input logic [DATA_W-1:0] count_rdata,
    input logic              pwr_down,
    input logic              sys_rst_pulse
);
    int unsigned hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             hi_len <= 0;
        else if (sys_rst_pulse) hi_len <= hi_len + 1;
        else                    hi_len <= 0;
    end

    // R4: width measured by a counter, not by a parameter-sized delay
    a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_pulse) |-> (hi_len == PULSE_CLKS));

    a_r4_clear_after: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_pulse) |-> (count_rdata == '0 && !le_bit && !pd_bit));

    a_r5_from_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_pulse) |-> ($past(count_rdata) == '1));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_pulse && $past(sys_rst_pulse)) |-> $stable(count_rdata));

    a_r6_frozen_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wd_en_n, 2) && $past(wd_en_n) && !$past(reg_we) && !$past(sys_rst_pulse))
        |-> $stable(count_rdata));

    a_r7_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_we && reg_sel && !le_bit && wd_en_n && !sys_rst_pulse) && $past(wd_en_n, 2))
        |-> $stable(count_rdata));

    a_r8_unlock_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_we && reg_sel && le_bit && !sys_rst_pulse) |-> !le_bit);

    a_r9_pd_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_en_n && $past(!wd_en_n)) |-> (!pd_bit && !pwr_down));
endmodule

bind wdog_core wdog_core_chk #(.DATA_W(DATA_W), .PULSE_CLKS(PULSE_CLKS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wd_en_n       (wd_en_n),
    .reg_we        (reg_we),
    .reg_sel       (reg_sel),
    .le_bit        (pctl_rdata[4]),
    .pd_bit        (pctl_rdata[1]),
    .count_rdata   (count_rdata),
    .pwr_down      (pwr_down),
    .sys_rst_pulse (sys_rst_pulse)
);

// File: tb/wdog_core_tb.sv
module wdog_core_tb;
    localparam int DIV    = 2;
    localparam int PRE    = 3;
    localparam int STEP   = DIV * (1 << PRE);
    localparam int PWIDTH = 3 * DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wd_en_n = 1'b1;
    logic       reg_we = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] pctl_rdata, count_rdata;
    logic       pwr_down, sys_rst_pulse;

    always #10 clk = ~clk;

    wdog_core #(.CLK_DIV(DIV), .PRE_BITS(PRE)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wd_en_n       (wd_en_n),
        .reg_we        (reg_we),
        .reg_sel       (reg_sel),
        .reg_wdata     (reg_wdata),
        .pctl_rdata    (pctl_rdata),
        .count_rdata   (count_rdata),
        .pwr_down      (pwr_down),
        .sys_rst_pulse (sys_rst_pulse)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Scoreboard: the driver queues the expected width of each pulse,
    // and the monitor measures every pulse and pops one entry for it.
    int pw_q[$];
    int hi_len = 0;

    always @(negedge clk) begin
        if (sys_rst_pulse) begin
            hi_len++;
        end else if (hi_len != 0) begin
            if (pw_q.size() == 0) chk("R4 unexpected pulse", hi_len, 0);
            else                  chk("R4 pulse width", hi_len, pw_q.pop_front());
            hi_len = 0;
        end
    end

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic load(input logic [7:0] v);
        wr(1'b0, 8'h10);
        wr(1'b1, v);
    endtask

    // Load v, count the edges until the pulse appears, and wait for its end.
    task automatic run_interval(string tag, input logic [7:0] v);
        int n;
        pw_q.push_back(PWIDTH);
        load(v);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!sys_rst_pulse && n < 20000);
        chk(tag, n, (256 - int'(v)) * STEP);
        while (sys_rst_pulse) @(negedge clk);
        chk("R4 count cleared after pulse", count_rdata, 0);
        chk("R4 control cleared after pulse", pctl_rdata, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count after reset", count_rdata, 0);
        chk("R1 control after reset", pctl_rdata, 0);
        chk("R1 pulse low after reset", sys_rst_pulse, 0);

        wr(1'b0, 8'h02);
        chk("R9 pd stored while off", pctl_rdata, 8'h02);
        chk("R9 pwr_down mirrors", pwr_down, 1);
        wr(1'b1, 8'h55);
        chk("R7 locked count write", count_rdata, 0);
        wr(1'b0, 8'h10);
        chk("R8 unlock set", pctl_rdata, 8'h10);
        wr(1'b1, 8'h55);
        chk("R8 count stored", count_rdata, 8'h55);
        chk("R8 unlock self-clears", pctl_rdata, 0);
        wr(1'b1, 8'h77);
        chk("R7 second write without unlock", count_rdata, 8'h55);
        repeat (100) @(negedge clk);
        chk("R6 count frozen while pin high", count_rdata, 8'h55);

        wr(1'b0, 8'h02);
        wd_en_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 pd cleared when enabled", pctl_rdata, 0);
        wr(1'b0, 8'h02);
        chk("R9 pd write ignored while enabled", pctl_rdata, 0);
        chk("R9 pwr_down low while enabled", pwr_down, 0);

        run_interval("R3 shortest interval FF", 8'hFF);

        load(8'hF0);
        repeat (3 * STEP) @(posedge clk);
        @(negedge clk);
        chk("R2 count rate", count_rdata, 8'hF3);
        // R10: reload mid-interval; the next interval must still be full length
        repeat (5) @(negedge clk);
        load(8'hFE);
        repeat (STEP + 5) @(negedge clk);
        run_interval("R10 interval repeatable after reload", 8'hFE);

        run_interval("R3 longest interval 00", 8'h00);

        load(8'hFC);
        repeat (STEP) @(posedge clk);
        @(negedge clk);
        chk("R2 one step after load", count_rdata, 8'hFD);
        wd_en_n = 1'b1;
        repeat (200) @(negedge clk);
        chk("R6 count frozen after pin rises", count_rdata, 8'hFD);
        chk("R6 no pulse while off", sys_rst_pulse, 0);
        chk("R4 all queued pulses seen", pw_q.size(), 0);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule